// File: doc/BRIEF.md
# Vectored Interrupt Request and Service Tracker

This block keeps the per-vector interrupt state for one interrupt unit. Four bitmaps each hold one bit per vector: pending requests, vectors in service, a raise-enable mask and a trigger-mode map. Sources raise an interrupt by giving its vector number. The block always shows whether a deliverable interrupt exists and which vector it is. When the processor takes that interrupt, the core acknowledges the vector. When the handler completes, an end-of-interrupt strobe retires the highest vector still in service.

Priority is simply the numeric vector value: a higher vector outranks a lower one. A request is deliverable only when its vector is above every vector already in service, so handlers nest by priority. Software sees each bitmap as eight 32-bit words on a simple register port. Only the enable words can be written.

Top module: `irq_vector_tracker`

## Requirements
- R1: After reset the request, in-service and trigger bitmaps are all zero, the enable bitmap is all ones, and pend_o and raise_err_o are low.
- R2: A raise of a valid vector whose enable bit is set sets its request bit at the next clock edge. Raising a vector that is already requested changes nothing.
- R3: A raise of a vector whose enable bit is clear leaves the request bitmap unchanged.
- R4: Vectors 0 to 15 are invalid. Raising one leaves the request bitmap unchanged and drives raise_err_o high for exactly the cycle after the edge that sampled it.
- R5: pend_o is high exactly when the request bitmap is non-empty and its highest set vector is strictly greater than the highest in-service vector, or the in-service bitmap is empty. While pend_o is high, pend_vec_o shows that highest requested vector. While pend_o is low, pend_vec_o is 0.
- R6: An acknowledge of vector v whose request bit is set clears that request bit and sets its in-service bit. An acknowledge of a vector whose request bit is clear is ignored.
- R7: An end-of-interrupt clears the highest set in-service bit. With the in-service bitmap empty it has no effect.
- R8: When end-of-interrupt, acknowledge and raise arrive in the same cycle, they are applied in this order: end-of-interrupt, then acknowledge, then raise. The acknowledge sees the request bitmap as it stood before the raise.
- R9: Register word k (k = 0 to 7) sits at base + 0x10*k. Bit j of word k is vector 32k+j. The bases are: in-service 0x100, trigger 0x180, request 0x200, enable 0x480. Address bits [3:0] are ignored. Any other address reads 0. Reads are combinational on reg_addr_i.
- R10: Only the enable words are writable. A write to any other address changes no state. An enable write first gates raises in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raise_valid_i | input | 1 | Raise request strobe |
| raise_vec_i | input | 8 | Vector to raise |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_i | input | 1 | End-of-interrupt strobe |
| pend_o | output | 1 | A deliverable interrupt exists |
| pend_vec_o | output | 8 | Vector of the deliverable interrupt |
| raise_err_o | output | 1 | Invalid-vector raise seen in the previous cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
The assertions take for granted that every input is driven to a known value from time zero. They also assume that reset is applied before the first strobe. Their checks on ignored raises and acknowledges leave out cases where another operation in the same cycle touches the same vector. The stimulus drives every strobe low at start-up and changes inputs only just after a rising edge. It collides operations on one vector only in the directed ordering tests, where the expected result follows the order set out in R8.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ISR,
    RGN_TRIG,
    RGN_IRR,
    RGN_EN
  } rgn_e;

  localparam int unsigned ISR_BASE  = 'h100;
  localparam int unsigned TRIG_BASE = 'h180;
  localparam int unsigned IRR_BASE  = 'h200;
  localparam int unsigned EN_BASE   = 'h480;
  localparam int unsigned WORD_STRIDE_LG2 = 4;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W     = 256,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     bits_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // last set bit in ascending scan is the highest vector
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_word_sel.sv
module irq_word_sel #(
  parameter int NUM_VEC = 256,
  parameter int DATA_W  = 32,
  parameter int NUM_WORDS = NUM_VEC / DATA_W,
  parameter int WSEL_W  = $clog2(NUM_WORDS)
) (
  input  logic [NUM_VEC-1:0] bits_i,
  input  logic [WSEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0]  word_o
);
  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign words[g] = bits_i[g*DATA_W +: DATA_W];
  end

  assign word_o = words[sel_i];
endmodule

// File: rtl/irq_vector_tracker.sv
module irq_vector_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_VEC     = 256,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int FIRST_VALID = 16,
  localparam int VEC_W      = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_valid_i,
  input  logic [VEC_W-1:0]  raise_vec_i,
  input  logic              ack_valid_i,
  input  logic [VEC_W-1:0]  ack_vec_i,
  input  logic              eoi_i,
  output logic              pend_o,
  output logic [VEC_W-1:0]  pend_vec_o,
  output logic              raise_err_o,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int NUM_WORDS = NUM_VEC / DATA_W;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int RGN_SH    = WORD_STRIDE_LG2 + WSEL_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, en_q, trig_q;
  logic [NUM_VEC-1:0] irr_n, isr_n;
  logic               err_q;

  logic             irr_found, isr_found;
  logic [VEC_W-1:0] irr_idx, isr_idx;

  irq_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_enc (
    .bits_i(irr_q), .found_o(irr_found), .idx_o(irr_idx)
  );
  irq_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_enc (
    .bits_i(isr_q), .found_o(isr_found), .idx_o(isr_idx)
  );

  assign pend_o     = irr_found && (!isr_found || (irr_idx > isr_idx));
  assign pend_vec_o = pend_o ? irr_idx : '0;

  logic raise_bad, raise_ok, ack_ok;
  assign raise_bad = raise_valid_i && (raise_vec_i < VEC_W'(FIRST_VALID));
  assign raise_ok  = raise_valid_i && !raise_bad && en_q[raise_vec_i];
  assign ack_ok    = ack_valid_i && irr_q[ack_vec_i];

  // order: eoi, ack, raise
  always_comb begin
    isr_n = isr_q;
    irr_n = irr_q;
    if (eoi_i && isr_found) isr_n[isr_idx] = 1'b0;
    if (ack_ok) begin
      isr_n[ack_vec_i] = 1'b1;
      irr_n[ack_vec_i] = 1'b0;
    end
    if (raise_ok) irr_n[raise_vec_i] = 1'b1;
  end

  // register decode
  rgn_e              rgn;
  logic [WSEL_W-1:0] wsel;
  logic [ADDR_W-1:0] rgn_tag;
  assign rgn_tag = reg_addr_i >> RGN_SH;
  assign wsel    = reg_addr_i[WORD_STRIDE_LG2 +: WSEL_W];

  always_comb begin
    if      (rgn_tag == ADDR_W'(ISR_BASE  >> RGN_SH)) rgn = RGN_ISR;
    else if (rgn_tag == ADDR_W'(TRIG_BASE >> RGN_SH)) rgn = RGN_TRIG;
    else if (rgn_tag == ADDR_W'(IRR_BASE  >> RGN_SH)) rgn = RGN_IRR;
    else if (rgn_tag == ADDR_W'(EN_BASE   >> RGN_SH)) rgn = RGN_EN;
    else                                              rgn = RGN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      en_q   <= '1;
      trig_q <= '0;
      err_q  <= 1'b0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      err_q <= raise_bad;
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (reg_wr_i && rgn == RGN_EN && wsel == WSEL_W'(k))
          en_q[k*DATA_W +: DATA_W] <= reg_wdata_i;
      end
    end
  end

  assign raise_err_o = err_q;

  logic [DATA_W-1:0] w_isr, w_trig, w_irr, w_en;
  irq_word_sel #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_rd_isr  (.bits_i(isr_q),  .sel_i(wsel), .word_o(w_isr));
  irq_word_sel #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_rd_trig (.bits_i(trig_q), .sel_i(wsel), .word_o(w_trig));
  irq_word_sel #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_rd_irr  (.bits_i(irr_q),  .sel_i(wsel), .word_o(w_irr));
  irq_word_sel #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_rd_en   (.bits_i(en_q),   .sel_i(wsel), .word_o(w_en));

  always_comb begin
    unique case (rgn)
      RGN_ISR:  reg_rdata_o = w_isr;
      RGN_TRIG: reg_rdata_o = w_trig;
      RGN_IRR:  reg_rdata_o = w_irr;
      RGN_EN:   reg_rdata_o = w_en;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_RAISE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_valid_i && !en_q[raise_vec_i] && !(ack_valid_i && ack_vec_i == raise_vec_i))
    |=> irr_q[$past(raise_vec_i)] == $past(irr_q[raise_vec_i])); // R3
  AST_INVALID_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_valid_i && raise_vec_i < VEC_W'(FIRST_VALID) && !(ack_valid_i && ack_vec_i == raise_vec_i))
    |=> raise_err_o && irr_q[$past(raise_vec_i)] == $past(irr_q[raise_vec_i])); // R4
  AST_PEND_ABOVE_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> irr_q[pend_vec_o] && ((isr_q >> pend_vec_o) == '0)); // R5
  AST_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && !irr_q[ack_vec_i] && !eoi_i)
    |=> isr_q[$past(ack_vec_i)] == $past(isr_q[ack_vec_i])); // R6
  AST_EOI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q != '0 && !ack_valid_i)
    |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R7
  AST_ORDER_ACK_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && raise_valid_i && ack_vec_i == raise_vec_i && irr_q[ack_vec_i]
     && en_q[raise_vec_i] && raise_vec_i >= VEC_W'(FIRST_VALID))
    |=> irr_q[$past(ack_vec_i)] && isr_q[$past(ack_vec_i)]); // R8
  AST_TRIG_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q == '0); // R10
endmodule

// File: tb/sim_irq_vector_tracker.sv
module sim_irq_vector_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_valid = 1'b0;
  logic [7:0]  raise_vec = '0;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_vec = '0;
  logic        eoi = 1'b0;
  logic        pend;
  logic [7:0]  pend_vec;
  logic        raise_err;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .raise_valid_i(raise_valid), .raise_vec_i(raise_vec),
    .ack_valid_i(ack_valid), .ack_vec_i(ack_vec),
    .eoi_i(eoi),
    .pend_o(pend), .pend_vec_o(pend_vec), .raise_err_o(raise_err),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // {raise vector, expected pend_vec afterwards}
  localparam logic [15:0] RAISE_TBL [6] = '{
    {8'd40,  8'd40},
    {8'd200, 8'd200},
    {8'd100, 8'd200},
    {8'd255, 8'd255},
    {8'd16,  8'd255},
    {8'd40,  8'd255}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, req);
  endtask

  task automatic do_raise(input logic [7:0] v);
    raise_valid = 1'b1; raise_vec = v;
    tick();
    raise_valid = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] v);
    ack_valid = 1'b1; ack_vec = v;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #12;
    rst_n = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk({31'd0, pend}, 32'd0, "R1 pend");
    chk({31'd0, raise_err}, 32'd0, "R1 err");
    for (int k = 0; k < 8; k++) begin
      rd(12'h480 + 12'(k*16), 32'hFFFF_FFFF, "R1 enable");
      rd(12'h100 + 12'(k*16), 32'h0, "R1 isr");
      rd(12'h180 + 12'(k*16), 32'h0, "R1 trig");
      rd(12'h200 + 12'(k*16), 32'h0, "R1 irr");
    end

    // R2 R5 table walk
    for (int i = 0; i < 6; i++) begin
      do_raise(RAISE_TBL[i][15:8]);
      chk({31'd0, pend}, 32'd1, "R5 pend table");
      chk({24'd0, pend_vec}, {24'd0, RAISE_TBL[i][7:0]}, "R2 R5 pend_vec table");
    end
    // R9 word layout, coalescing kept one bit for 40
    rd(12'h200, 32'h0001_0000, "R9 irr word0");
    rd(12'h210, 32'h0000_0100, "R2 R9 irr word1");
    rd(12'h230, 32'h0000_0010, "R9 irr word3");
    rd(12'h26C, 32'h0000_0100, "R9 irr word6 low bits ignored");
    rd(12'h270, 32'h8000_0000, "R9 irr word7");

    // R6 ack moves 255
    do_ack(8'd255);
    chk({31'd0, pend}, 32'd0, "R5 R6 pend below isr");
    rd(12'h170, 32'h8000_0000, "R6 isr word7");
    rd(12'h270, 32'h0, "R6 irr word7");
    // R6 ack of unrequested vector ignored
    do_ack(8'd77);
    rd(12'h120, 32'h0, "R6 ignored ack isr");
    rd(12'h220, 32'h0, "R6 ignored ack irr");

    // R7 eoi
    do_eoi();
    rd(12'h170, 32'h0, "R7 eoi clears");
    chk({31'd0, pend}, 32'd1, "R7 pend after eoi");
    chk({24'd0, pend_vec}, 32'd200, "R7 pend_vec after eoi");
    do_eoi();
    chk({24'd0, pend_vec}, 32'd200, "R7 eoi empty no effect");
    rd(12'h270, 32'h0, "R7 eoi empty irr");

    // nesting
    do_ack(8'd200);
    chk({31'd0, pend}, 32'd0, "R5 100 below 200");
    do_raise(8'd220);
    chk({31'd0, pend}, 32'd1, "R5 nested pend");
    chk({24'd0, pend_vec}, 32'd220, "R5 nested vec");
    rd(12'h160, 32'h0000_0100, "R9 isr word6");

    // R3 R10 disabled vector
    do_write(12'h4C0, 32'hFFFF_FFFE);
    rd(12'h4C0, 32'hFFFF_FFFE, "R10 enable readback");
    do_raise(8'd128);
    rd(12'h240, 32'h0, "R3 masked raise");
    chk({24'd0, pend_vec}, 32'd220, "R3 pend unaffected");
    do_write(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, 32'h0001_0000, "R10 irr not writable");
    do_write(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, 32'h0, "R10 trig not writable");
    rd(12'h300, 32'h0, "R9 unmapped reads zero");

    // R4 invalid vector
    do_raise(8'd5);
    chk({31'd0, raise_err}, 32'd1, "R4 err set");
    rd(12'h200, 32'h0001_0000, "R4 irr unchanged");
    tick();
    chk({31'd0, raise_err}, 32'd0, "R4 err one cycle");

    // R8 ordering
    do_reset();
    do_raise(8'd50);
    ack_valid = 1'b1; ack_vec = 8'd50;
    raise_valid = 1'b1; raise_vec = 8'd50;
    tick();
    ack_valid = 1'b0; raise_valid = 1'b0;
    rd(12'h110, 32'h0004_0000, "R8 ack then raise isr");
    rd(12'h210, 32'h0004_0000, "R8 ack then raise irr");
    eoi = 1'b1; ack_valid = 1'b1; ack_vec = 8'd50;
    tick();
    eoi = 1'b0; ack_valid = 1'b0;
    rd(12'h110, 32'h0004_0000, "R8 eoi then ack isr");
    rd(12'h210, 32'h0, "R8 eoi then ack irr");
    chk({31'd0, pend}, 32'd0, "R8 pend");

    finish_run();
  end
endmodule